// File: doc/BRIEF.md
# Wavefront issue arbiter

This block is the issue front end of one compute unit. It has four 16-lane SIMD units, and each SIMD owns a pool of resident wavefront slots. Every wavefront slot offers the head instruction of its in-order stream. The slot raises a valid flag and tags the instruction with a 3-bit class. The arbiter replies with a per-slot ready pulse, and an instruction counts as taken in a cycle where both valid and ready are high.

Each cycle the arbiter serves one SIMD, in fixed rotation. A 64-item wavefront occupies a 16-lane SIMD for four cycles, so each SIMD gets one issue turn every four cycles. Within the served SIMD's pool, the arbiter picks at most one instruction per class. Each slot has only one head instruction, so every instruction issued in a cycle comes from a different wavefront. When several slots compete for a class, the oldest one wins, judged by an allocation age supplied for each slot.

A per-SIMD busy counter tracks the vector ALU port. A vector ALU instruction is held back while its SIMD still has busy cycles left from an earlier one. The arbiter also reports a per-cycle bitmap of the classes it issued.

The rotation is a state machine with five states:
- TS_WAIT is the single idle cycle after reset.
- TS_SIMD0, TS_SIMD1, TS_SIMD2 and TS_SIMD3 are the issue turns.

There are two transitions. TS_WAIT goes to TS_SIMD0 on the first clock after reset. After that, each TS_SIMDn goes to TS_SIMD(n+1 mod 4) on every clock.

Top module: `wfi_issue_arbiter`

## Requirements
- R1: In the first cycle after reset is released, turn_valid is 0 and no wf_ready bit is set. The next cycle serves SIMD 0.
- R2: From then on, turn advances 0,1,2,3,0,… by one each cycle, with turn_valid high.
- R3: Only slots of the served SIMD may receive ready. Slot index = simd*WF_PER_SIMD + k, for k in 0..WF_PER_SIMD-1.
- R4: The class codes are: 0 branch, 1 scalar ALU/memory, 2 vector ALU, 3 vector memory, 4 local data share, 5 global data share/export, 6 special. At most one instruction per class issues per cycle, and code 7 never issues.
- R5: Among valid slots of the served pool with the same class, the one with the smallest wf_age issues. On equal age, the lower slot index issues.
- R6: Instructions of different classes from different slots of the served pool issue in the same cycle. Bit c of issue_bitmap is set exactly when class c issued.
- R7: A vector ALU issue makes that SIMD's vector port busy for VALU_BUSY_CYC cycles. A vector ALU instruction of a SIMD with busy cycles left does not issue. Other classes of that SIMD, and other SIMDs, are unaffected.
- R8: wf_ready is set only for valid slots. The number of ready bits equals the number of set issue_bitmap bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wf_valid | input | NUM_SIMD*WF_PER_SIMD | Head instruction present, one bit per slot |
| wf_class | input | 3*NUM_SIMD*WF_PER_SIMD | Class code of each slot's head instruction |
| wf_age | input | AGE_W*NUM_SIMD*WF_PER_SIMD | Allocation age per slot, smaller is older |
| wf_ready | output | NUM_SIMD*WF_PER_SIMD | Issue acceptance per slot |
| issue_bitmap | output | 7 | Classes issued this cycle |
| turn | output | 2 | SIMD served this cycle |
| turn_valid | output | 1 | An issue turn is active |

## Verification
The bench builds the arbiter with three slots per SIMD, 4-bit ages and a vector busy time of six cycles. Six cycles is longer than the four-cycle rotation, so a SIMD's next turn after a vector ALU issue arrives while its port is still busy. The same run also reaches the turn after that, when the port is free again. Three slots per pool are enough to test an age win against slot order, an age tie, an invalid class code, and three classes issuing together.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
    localparam int NUM_SIMD  = 4;
    localparam int NUM_CLASS = 7;
    localparam int CLS_W     = 3;
    localparam logic [CLS_W-1:0] CLS_VALU = 3'd2;

    typedef enum logic [2:0] {
        TS_WAIT,
        TS_SIMD0,
        TS_SIMD1,
        TS_SIMD2,
        TS_SIMD3
    } turn_e;
endpackage

// File: rtl/wfi_oldest_pick.sv
module wfi_oldest_pick #(
    parameter int W     = 10,
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     cand,
    input  logic [W*AGE_W-1:0] ages,
    output logic [W-1:0]     grant
);
    logic             found;
    logic [AGE_W-1:0] best;
    int               pick;

    always_comb begin
        grant = '0;
        found = 1'b0;
        best  = '0;
        pick  = 0;
        for (int i = 0; i < W; i++) begin
            if (cand[i] && (!found || ages[i*AGE_W +: AGE_W] < best)) begin
                found = 1'b1;
                best  = ages[i*AGE_W +: AGE_W];
                pick  = i;
            end
        end
        if (found) grant[pick] = 1'b1;
    end

    // R4: a single winner per class picker
    p_one_winner_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R5: a winner must be a candidate
    p_grant_cand_r5: assert property (@(posedge clk) disable iff (rst)
        (grant & ~cand) == '0);
endmodule

// File: rtl/wfi_valu_busy.sv
module wfi_valu_busy #(
    parameter int NUM_SIMD = 4,
    parameter int BUSY_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SIMD-1:0] load,
    output logic [NUM_SIMD-1:0] free
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)          cnt <= '0;
            else if (load[s]) cnt <= RELOAD;
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
        assign free[s] = (cnt == '0);

        // R7: counter restarts with the full busy time after an issue
        p_busy_reload_r7: assert property (@(posedge clk) disable iff (rst)
            load[s] |=> cnt == RELOAD);
        // R7: the issuer never loads a port that is still busy
        p_no_issue_busy_r7: assert property (@(posedge clk) disable iff (rst)
            load[s] |-> cnt == '0);
    end
endmodule

// File: rtl/wfi_issue_arbiter.sv
module wfi_issue_arbiter
    import wfi_pkg::*;
#(
    parameter int WF_PER_SIMD   = 10,
    parameter int AGE_W         = 8,
    parameter int VALU_BUSY_CYC = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_valid,
    input  logic [NUM_SIMD*WF_PER_SIMD*CLS_W-1:0] wf_class,
    input  logic [NUM_SIMD*WF_PER_SIMD*AGE_W-1:0] wf_age,
    output logic [NUM_SIMD*WF_PER_SIMD-1:0]       wf_ready,
    output logic [NUM_CLASS-1:0]                  issue_bitmap,
    output logic [1:0]                            turn,
    output logic                                  turn_valid
);
    localparam int NSLOT = NUM_SIMD * WF_PER_SIMD;

    turn_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= TS_WAIT;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            TS_WAIT:  state_nx = TS_SIMD0;
            TS_SIMD0: state_nx = TS_SIMD1;
            TS_SIMD1: state_nx = TS_SIMD2;
            TS_SIMD2: state_nx = TS_SIMD3;
            TS_SIMD3: state_nx = TS_SIMD0;
            default:  state_nx = TS_WAIT;
        endcase
    end

    always_comb begin
        unique case (state)
            TS_SIMD0: begin turn = 2'd0; turn_valid = 1'b1; end
            TS_SIMD1: begin turn = 2'd1; turn_valid = 1'b1; end
            TS_SIMD2: begin turn = 2'd2; turn_valid = 1'b1; end
            TS_SIMD3: begin turn = 2'd3; turn_valid = 1'b1; end
            default:  begin turn = 2'd0; turn_valid = 1'b0; end
        endcase
    end

    // Select the served SIMD's pool
    logic [WF_PER_SIMD-1:0]       pool_valid;
    logic [WF_PER_SIMD*CLS_W-1:0] pool_cls;
    logic [WF_PER_SIMD*AGE_W-1:0] pool_age;
    logic [NUM_SIMD-1:0]          simd_free;
    logic [NUM_SIMD-1:0]          valu_load;

    always_comb begin
        pool_valid = '0;
        pool_cls   = '0;
        pool_age   = '0;
        for (int s = 0; s < NUM_SIMD; s++) begin
            if (turn_valid && turn == 2'(s)) begin
                pool_valid = wf_valid[s*WF_PER_SIMD +: WF_PER_SIMD];
                pool_cls   = wf_class[s*WF_PER_SIMD*CLS_W +: WF_PER_SIMD*CLS_W];
                pool_age   = wf_age[s*WF_PER_SIMD*AGE_W +: WF_PER_SIMD*AGE_W];
            end
        end
    end

    logic [WF_PER_SIMD-1:0] gnt [NUM_CLASS];

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        logic [WF_PER_SIMD-1:0] cand;
        always_comb begin
            for (int k = 0; k < WF_PER_SIMD; k++) begin
                cand[k] = pool_valid[k] && (pool_cls[k*CLS_W +: CLS_W] == CLS_W'(c));
            end
            if (CLS_W'(c) == CLS_VALU && !simd_free[turn]) cand = '0;
        end
        wfi_oldest_pick #(.W(WF_PER_SIMD), .AGE_W(AGE_W)) u_pick (
            .clk   (clk),
            .rst   (rst),
            .cand  (cand),
            .ages  (pool_age),
            .grant (gnt[c])
        );
        assign issue_bitmap[c] = |gnt[c];
    end

    logic [WF_PER_SIMD-1:0] pool_grant;
    always_comb begin
        pool_grant = '0;
        for (int c = 0; c < NUM_CLASS; c++) pool_grant = pool_grant | gnt[c];
    end

    always_comb begin
        wf_ready = '0;
        for (int s = 0; s < NUM_SIMD; s++) begin
            valu_load[s] = turn_valid && turn == 2'(s) && issue_bitmap[CLS_VALU];
            if (turn_valid && turn == 2'(s))
                wf_ready[s*WF_PER_SIMD +: WF_PER_SIMD] = pool_grant;
        end
    end

    wfi_valu_busy #(.NUM_SIMD(NUM_SIMD), .BUSY_CYC(VALU_BUSY_CYC)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (valu_load),
        .free (simd_free)
    );

    // Assertions
    logic [NSLOT-1:0] served_mask;
    always_comb begin
        served_mask = '0;
        if (turn_valid)
            for (int k = 0; k < WF_PER_SIMD; k++)
                served_mask[int'(turn)*WF_PER_SIMD + k] = 1'b1;
    end

    p_wait_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !turn_valid && wf_ready == '0);
    p_rotate_r2: assert property (@(posedge clk) disable iff (rst)
        turn_valid && $past(turn_valid) |-> turn == 2'($past(turn) + 2'd1));
    p_served_pool_r3: assert property (@(posedge clk) disable iff (rst)
        (wf_ready & ~served_mask) == '0);
    p_one_per_wf_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(wf_ready) == $countones(issue_bitmap));
    p_ready_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (wf_ready & ~wf_valid) == '0);
endmodule

// File: tb/wfi_issue_arbiter_tb_top.sv
`timescale 1ns/1ps
module wfi_issue_arbiter_tb_top;
    localparam int WPS = 3;
    localparam int AW  = 4;
    localparam int N   = 4 * WPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]    v;
    logic [2:0]      c [N];
    logic [AW-1:0]   a [N];
    logic [N*3-1:0]  cls_bus;
    logic [N*AW-1:0] age_bus;
    logic [N-1:0]    rdy;
    logic [6:0]      bm;
    logic [1:0]      turn;
    logic            turn_valid;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cls_bus[i*3 +: 3]   = c[i];
            age_bus[i*AW +: AW] = a[i];
        end
    end

    wfi_issue_arbiter #(.WF_PER_SIMD(WPS), .AGE_W(AW), .VALU_BUSY_CYC(6)) dut_i (
        .clk(clk), .rst(rst), .wf_valid(v), .wf_class(cls_bus), .wf_age(age_bus),
        .wf_ready(rdy), .issue_bitmap(bm), .turn(turn), .turn_valid(turn_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [N-1:0] q_rdy [$];
    logic [6:0]   q_bm  [$];
    int           q_tn  [$];
    string        q_tag [$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input logic [N-1:0] er, input logic [6:0] eb,
                               input int et, input string tag);
        q_rdy.push_back(er);
        q_bm.push_back(eb);
        q_tn.push_back(et);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (q_rdy.size() > 0) begin
            logic [N-1:0] er;
            logic [6:0]   eb;
            int           et;
            string        tg;
            er = q_rdy.pop_front();
            eb = q_bm.pop_front();
            et = q_tn.pop_front();
            tg = q_tag.pop_front();
            chk("R2", "turn_valid", int'(turn_valid), 1);
            chk("R2", "turn", int'(turn), et);
            chk(tg, "wf_ready", int'(rdy), int'(er));
            chk(tg, "issue_bitmap", int'(bm), int'(eb));
        end
    end

    task automatic clear_inputs();
        v = '0;
        for (int i = 0; i < N; i++) begin
            c[i] = 3'd0;
            a[i] = '0;
        end
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R1", "turn_valid after reset", int'(turn_valid), 0);
        chk("R1", "wf_ready after reset", int'(rdy), 0);

        // k0, SIMD0: idle
        next_cycle(); clear_inputs();
        expect_item(12'h000, 7'h00, 0, "R1");

        // k1, SIMD1: age beats index; vmem alongside; slot0 outside pool
        next_cycle(); clear_inputs();
        v[0]=1; c[0]=3'd0;
        v[3]=1; c[3]=3'd2; a[3]=4'd5;
        v[4]=1; c[4]=3'd2; a[4]=4'd3;
        v[5]=1; c[5]=3'd3; a[5]=4'd1;
        expect_item(12'b0000_0011_0000, 7'b000_1100, 1, "R5");

        // k2, SIMD2: age tie -> lower index; code 7 ignored
        next_cycle(); clear_inputs();
        v[6]=1; c[6]=3'd0; a[6]=4'd2;
        v[7]=1; c[7]=3'd0; a[7]=4'd2;
        v[8]=1; c[8]=3'd7; a[8]=4'd0;
        expect_item(12'b0000_0100_0000, 7'b000_0001, 2, "R4");

        // k3, SIMD3: three classes from three slots
        next_cycle(); clear_inputs();
        v[9]=1;  c[9]=3'd4;  a[9]=4'd7;
        v[10]=1; c[10]=3'd5; a[10]=4'd1;
        v[11]=1; c[11]=3'd6; a[11]=4'd4;
        expect_item(12'b1110_0000_0000, 7'b111_0000, 3, "R6");

        // k4, SIMD0: oldest valu plus scalar
        next_cycle(); clear_inputs();
        v[0]=1; c[0]=3'd2; a[0]=4'd9;
        v[1]=1; c[1]=3'd2; a[1]=4'd2;
        v[2]=1; c[2]=3'd1; a[2]=4'd6;
        expect_item(12'b0000_0000_0110, 7'b000_0110, 0, "R5");

        // k5, SIMD1: valu still busy, special issues
        next_cycle(); clear_inputs();
        v[3]=1; c[3]=3'd2; a[3]=4'd5;
        v[4]=1; c[4]=3'd6; a[4]=4'd3;
        expect_item(12'b0000_0001_0000, 7'b100_0000, 1, "R7");

        // k6, k7: only an out-of-pool request present
        next_cycle(); clear_inputs();
        v[0]=1; c[0]=3'd2;
        expect_item(12'h000, 7'h00, 2, "R3");
        next_cycle();
        expect_item(12'h000, 7'h00, 3, "R3");

        // k8, SIMD0: valu busy, vmem issues
        next_cycle(); clear_inputs();
        v[0]=1; c[0]=3'd2; a[0]=4'd0;
        v[1]=1; c[1]=3'd3; a[1]=4'd1;
        expect_item(12'b0000_0000_0010, 7'b000_1000, 0, "R7");

        // k9, SIMD1: busy time elapsed, valu issues; invalid slot stays idle
        next_cycle(); clear_inputs();
        v[3]=1; c[3]=3'd2; a[3]=4'd5;
        c[4]=3'd0;
        expect_item(12'b0000_0000_1000, 7'b000_0100, 1, "R8");

        next_cycle(); clear_inputs();
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule